// File: doc/BRIEF.md
# In-Group Store-to-Load Alias Detector

This block watches the memory accesses placed into one dispatch group and raises a no-op hazard when a load in that group may read bytes written by a store placed earlier in the same group. It computes no real address. Every access carries two symbolic address operands and a size code. Each operand is either a register identifier or a constant offset. Overlap is decided only from the identity of the operands and from the ranges of constant offsets.

The block keeps up to four store records for each group. A load is checked against all valid records at once, and the hazard output is combinational in the cycle the load is presented. A group-end pulse clears every record at the next clock edge. A store beyond the fourth in one group is dropped, and a sticky flag reports the drop until the group ends.

Top module: `ldst_alias_det`

## Requirements
- R1: After reset the store count is 0, the overflow flag is 0, and a load raises no hazard.
- R2: A store presented without group end writes a record at the index equal to the current count. The count rises by one at the next clock edge and never exceeds 4.
- R3: A store presented while the count is 4 is ignored. The four existing records stay unchanged, so a load equal to the ignored store raises no hazard. The overflow flag goes to 1 at the next edge and stays set until group end.
- R4: Each operand is 17 bits: bit 16 is the tag (1 = constant, 0 = register) and bits 15:0 are the payload. A load whose first and second operands equal a record's first and second operands raises the hazard in the same cycle.
- R5: A load whose first operand equals a record's second operand, and whose second operand equals that record's first operand, raises the hazard.
- R6: When the second operands are equal and both first operands are constants, the payloads are read as signed offsets. If the store offset is below the load offset, the hazard is raised exactly when store offset plus store size exceeds the load offset.
- R7: In the same case, if the store offset is not below the load offset, the hazard is raised exactly when load offset plus load size exceeds the store offset. Equal offsets always overlap. In every other case a differing operand gives no hazard.
- R8: The hazard is only raised for a load presented while at least one record exists. A store never raises it, and neither does any cycle with no access.
- R9: Group end clears all records and the overflow flag at the next edge. A load in the same cycle is still checked against the old records. A store in the same cycle becomes record 0 of the new group, leaving the count at 1.
- R10: The 3-bit size code n (0 to 4) means 2^n bytes: 1, 2, 4, 8 or 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| grp_end_i | input | 1 | Current dispatch group ends at this edge |
| acc_valid_i | input | 1 | An access is presented this cycle |
| acc_store_i | input | 1 | 1 = store, 0 = load |
| acc_opa_i | input | 17 | First address operand (tag bit 16, payload 15:0) |
| acc_opb_i | input | 17 | Second address operand (tag bit 16, payload 15:0) |
| acc_size_i | input | 3 | Size code, 2^n bytes |
| hazard_o | output | 1 | Load may alias a store of this group |
| store_cnt_o | output | 3 | Number of store records held |
| overflow_o | output | 1 | A store was dropped in this group |

## Verification
Two functions can act in the same cycle. A load check can coincide with the group-end clear, and a store append can also coincide with that clear. The bench presents a load in the group-end cycle and expects a hazard judged against the old records, followed by an empty count. It also presents a store in a group-end cycle after an overflow, and expects a count of 1 with the flag cleared, then a hit on that store in the following group. A behavioural queue model is compared against the hazard, count and flag on every clock.

// File: rtl/alias_pkg.sv
package alias_pkg;
  // Bytes covered by a size code.
  function automatic int size_bytes(input logic [2:0] code);
    return 1 << code;
  endfunction

  // Signed offset ranges: store [so, so+ss), load [lo, lo+ls).
  function automatic logic ofs_overlap(input int so, input int ss,
                                       input int lo, input int ls);
    if (so < lo) return (so + ss) > lo;
    else         return (lo + ls) > so;
  endfunction
endpackage

// File: rtl/alias_slot.sv
module alias_slot
  import alias_pkg::*;
#(
  parameter int OFS_W = 16
) (
  input  logic             rec_vld,
  input  logic [OFS_W:0]   rec_a,
  input  logic [OFS_W:0]   rec_b,
  input  logic [2:0]       rec_sz,
  input  logic [OFS_W:0]   ld_a,
  input  logic [OFS_W:0]   ld_b,
  input  logic [2:0]       ld_sz,
  output logic             hit
);
  localparam int TAG = OFS_W;

  logic same_order, swapped, both_const, range_hit;
  int   s_off, l_off;

  always_comb begin
    same_order = (ld_a == rec_a) && (ld_b == rec_b);
    swapped    = (ld_a == rec_b) && (ld_b == rec_a);
    both_const = rec_a[TAG] && ld_a[TAG] && (ld_b == rec_b);
    s_off      = int'($signed(rec_a[OFS_W-1:0]));
    l_off      = int'($signed(ld_a[OFS_W-1:0]));
    range_hit  = both_const &&
                 ofs_overlap(s_off, size_bytes(rec_sz), l_off, size_bytes(ld_sz));
    hit        = rec_vld && (same_order || swapped || range_hit);
  end
endmodule

// File: rtl/store_book.sv
module store_book #(
  parameter int OFS_W = 16,
  parameter int DEPTH = 4,
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           grp_end,
  input  logic           push,
  input  logic [OFS_W:0] st_a,
  input  logic [OFS_W:0] st_b,
  input  logic [2:0]     st_sz,
  output logic [OFS_W:0] rec_a  [DEPTH],
  output logic [OFS_W:0] rec_b  [DEPTH],
  output logic [2:0]     rec_sz [DEPTH],
  output logic [DEPTH-1:0] rec_vld,
  output logic [CW-1:0]  cnt,
  output logic           ovf
);
  logic          full;
  logic          do_append;
  logic          drop_evt;
  logic [IW-1:0] wr_idx;

  assign full      = (cnt == CW'(DEPTH));
  assign do_append = push && (grp_end || !full);
  assign drop_evt  = push && !grp_end && full;
  assign wr_idx    = grp_end ? '0 : cnt[IW-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      ovf <= 1'b0;
    end else if (grp_end) begin
      cnt <= push ? CW'(1) : '0;
      ovf <= 1'b0;
    end else if (push) begin
      if (full) ovf <= 1'b1;
      else      cnt <= cnt + CW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (do_append) begin
      rec_a[wr_idx]  <= st_a;
      rec_b[wr_idx]  <= st_b;
      rec_sz[wr_idx] <= st_sz;
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_vld
    assign rec_vld[i] = (cnt > CW'(i));
  end

  p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));
  p_cnt_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    push && !grp_end && !full |=> cnt == $past(cnt) + CW'(1));
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    drop_evt |=> ovf && cnt == CW'(DEPTH));
  p_rec_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    drop_evt |=> $stable(rec_a[0]) && $stable(rec_b[0]));
  p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    grp_end |=> !ovf && cnt == (($past(push)) ? CW'(1) : CW'(0)));
endmodule

// File: rtl/ldst_alias_det.sv
module ldst_alias_det #(
  parameter int OFS_W = 16,
  parameter int DEPTH = 4,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           grp_end_i,
  input  logic           acc_valid_i,
  input  logic           acc_store_i,
  input  logic [OFS_W:0] acc_opa_i,
  input  logic [OFS_W:0] acc_opb_i,
  input  logic [2:0]     acc_size_i,
  output logic           hazard_o,
  output logic [CW-1:0]  store_cnt_o,
  output logic           overflow_o
);
  logic [OFS_W:0]   rec_a  [DEPTH];
  logic [OFS_W:0]   rec_b  [DEPTH];
  logic [2:0]       rec_sz [DEPTH];
  logic [DEPTH-1:0] rec_vld;
  logic [DEPTH-1:0] slot_hit;
  logic             st_push, ld_check;

  assign st_push  = acc_valid_i && acc_store_i;
  assign ld_check = acc_valid_i && !acc_store_i && (store_cnt_o != '0);

  store_book #(.OFS_W(OFS_W), .DEPTH(DEPTH)) u_book (
    .clk(clk), .rst_n(rst_n), .grp_end(grp_end_i), .push(st_push),
    .st_a(acc_opa_i), .st_b(acc_opb_i), .st_sz(acc_size_i),
    .rec_a(rec_a), .rec_b(rec_b), .rec_sz(rec_sz), .rec_vld(rec_vld),
    .cnt(store_cnt_o), .ovf(overflow_o)
  );

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    alias_slot #(.OFS_W(OFS_W)) u_slot (
      .rec_vld(rec_vld[i]), .rec_a(rec_a[i]), .rec_b(rec_b[i]),
      .rec_sz(rec_sz[i]), .ld_a(acc_opa_i), .ld_b(acc_opb_i),
      .ld_sz(acc_size_i), .hit(slot_hit[i])
    );
  end

  assign hazard_o = ld_check && (|slot_hit);

  p_store_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    st_push |-> !hazard_o);
  p_empty_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    store_cnt_o == '0 |-> !hazard_o);
  p_exact_hit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid_i && !acc_store_i && rec_vld[0] &&
    acc_opa_i == rec_a[0] && acc_opb_i == rec_b[0] |-> hazard_o);
  p_swap_hit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid_i && !acc_store_i && rec_vld[0] &&
    acc_opa_i == rec_b[0] && acc_opb_i == rec_a[0] |-> hazard_o);
endmodule

// File: tb/sim_ldst_alias_det.sv
module sim_ldst_alias_det;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        grp_end_i = 0, acc_valid_i = 0, acc_store_i = 0;
  logic [16:0] acc_opa_i = '0, acc_opb_i = '0;
  logic [2:0]  acc_size_i = '0;
  logic        hazard_o, overflow_o;
  logic [2:0]  store_cnt_o;

  int checks = 0, failures = 0;
  bit done = 0;

  // behavioural model state
  int  m_a[$], m_b[$], m_sz[$];
  bit  m_ovf = 0;

  always #5 clk = ~clk;

  ldst_alias_det u0 (.*);

  function automatic logic [16:0] R(input int n); return {1'b0, 16'(n)}; endfunction
  function automatic logic [16:0] C(input int n); return {1'b1, 16'(n)}; endfunction

  task automatic chk(input int got, input int exp, input string req);
    checks++;
    if (got != exp) begin
      failures++;
      $display("FAIL %s got=%0d exp=%0d at %0t", req, got, exp, $time);
    end
  endtask

  function automatic bit model_hit(input int la, input int lb, input int lsz);
    for (int i = 0; i < m_a.size(); i++) begin
      if (la == m_a[i] && lb == m_b[i]) return 1;
      if (la == m_b[i] && lb == m_a[i]) return 1;
      if (lb == m_b[i] && la[16] && m_a[i][16]) begin
        int so = int'($signed(m_a[i][15:0]));
        int lo = int'($signed(la[15:0]));
        int se = so + (2 ** m_sz[i]);
        int le = lo + (2 ** lsz);
        int st = (so > lo) ? so : lo;
        int en = (se < le) ? se : le;
        if (st < en) return 1;
      end
    end
    return 0;
  endfunction

  task automatic step(input bit ge, input bit v, input bit st,
                      input logic [16:0] a, input logic [16:0] b,
                      input int sz, input string req);
    bit exp_hz;
    @(negedge clk);
    grp_end_i = ge; acc_valid_i = v; acc_store_i = st;
    acc_opa_i = a; acc_opb_i = b; acc_size_i = 3'(sz);
    #1;
    exp_hz = v && !st && model_hit(int'(a), int'(b), sz);
    chk(int'(hazard_o), int'(exp_hz), req);
    chk(int'(store_cnt_o), m_a.size(), "R2");
    chk(int'(overflow_o), int'(m_ovf), "R3");
    @(posedge clk);
    if (ge) begin
      m_a.delete(); m_b.delete(); m_sz.delete(); m_ovf = 0;
      if (v && st) begin m_a.push_back(int'(a)); m_b.push_back(int'(b)); m_sz.push_back(sz); end
    end else if (v && st) begin
      if (m_a.size() < 4) begin
        m_a.push_back(int'(a)); m_b.push_back(int'(b)); m_sz.push_back(sz);
      end else m_ovf = 1;
    end
  endtask

  task automatic ld(input logic [16:0] a, input logic [16:0] b, input int sz, input string req);
    step(0, 1, 0, a, b, sz, req);
  endtask
  task automatic sto(input logic [16:0] a, input logic [16:0] b, input int sz, input string req);
    step(0, 1, 1, a, b, sz, req);
  endtask

  initial begin
    int cyc = 0;
    while (!done && cyc < 100000) begin @(posedge clk); cyc++; end
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    // R1: reset state, empty group load
    step(0, 0, 0, '0, '0, 0, "R1");
    ld(R(3), C(8), 2, "R1");
    // R4 exact, R5 swapped
    sto(C(8), R(3), 2, "R2");
    ld(C(8), R(3), 2, "R4");
    ld(R(3), C(8), 2, "R5");
    ld(C(8), R(4), 2, "R7");
    ld(R(9), R(3), 2, "R7");
    // R6: store below load, 8..11
    ld(C(12), R(3), 2, "R6");
    ld(C(11), R(3), 0, "R6");
    // R7: load below or equal
    ld(C(4), R(3), 2, "R7");
    ld(C(5), R(3), 2, "R7");
    ld(C(8), R(3), 0, "R7");
    // R8: store identical never flags
    sto(C(8), R(3), 2, "R8");
    step(0, 0, 0, C(8), R(3), 2, "R8");
    // R9: load in group-end cycle checked against old records
    step(1, 1, 0, C(9), R(3), 0, "R9");
    ld(C(9), R(3), 0, "R9");
    // negative offsets, R10 sizes
    sto(C(-4), R(7), 2, "R10");
    ld(C(-1), R(7), 0, "R6");
    ld(C(0), R(7), 0, "R6");
    sto(C(0), R(5), 4, "R10");
    ld(C(15), R(5), 0, "R10");
    ld(C(16), R(5), 0, "R10");
    ld(C(-8), R(5), 3, "R10");
    ld(C(-9), R(5), 3, "R10");
    // fill and overflow, R3
    sto(R(1), R(2), 3, "R2");
    sto(R(10), R(11), 3, "R2");
    sto(R(20), R(21), 3, "R3");
    sto(R(20), R(21), 3, "R3");
    ld(R(20), R(21), 3, "R3");
    ld(C(-1), R(7), 0, "R3");
    ld(R(2), R(1), 3, "R5");
    // R9: store with group end starts new group
    step(1, 1, 1, R(30), C(2), 1, "R9");
    ld(R(30), C(2), 1, "R9");
    ld(C(-1), R(7), 0, "R9");
    step(1, 0, 0, '0, '0, 0, "R9");
    ld(R(30), C(2), 1, "R8");
    step(0, 0, 0, '0, '0, 0, "R1");
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule